// File: doc/BRIEF.md
# SPI Register Access Slave

This block is the host-side front end of a one- or two-channel UART. A host drives it as an SPI slave in mode 0, with an active-low chip select framing each transaction and 8-bit frames sent most significant bit first. The first byte of every transaction is a command. It holds a read flag, a four-bit register index and a two-bit channel number. For a write, the command is followed by a data byte. For a read, the host clocks in a dummy byte, typically 0xFF, and the slave shifts the register value out on MISO during that byte.

Accesses to the UART register file leave the block as single-cycle request pulses on a simple register bus. Read data comes back on that bus with a latency of one cycle. Writes to the holding register (index 0) are special: while chip select stays low, every further byte becomes another push into the transmit FIFO. This lets the host stream a block of characters after a single command.

Three read-only registers are answered inside the block from per-channel level inputs, with no bus traffic:
- the transmit free-space count,
- the receive fill count,
- a line status byte.

The serial inputs are oversampled by the system clock. Each SCLK half period must therefore last at least four system clock cycles.

Top module: `spi_reg_slave`

## Requirements
- R1: The slave samples MOSI on rising SCLK edges, most significant bit first. It updates MISO only after falling SCLK edges. MISO is 0 while chip select is high, during the command byte, during write data bytes, and during any byte that has no read data to return.
- R2: The command byte is decoded as follows: bit 7 is the read flag (1 means read), bits [6:3] are the register index, and bits [2:1] are the channel. Bit 0 is ignored.
- R3: A write to a bus register issues exactly one `busReq` pulse, one cycle long, with `busWe`=1, the index, the channel and the data byte. For any index other than 0, data bytes after the first are ignored and issue no request.
- R4: For a write to index 0, every complete data byte received while chip select stays low issues its own write request to index 0, in arrival order.
- R5: A read of a bus register issues one `busReq` pulse with `busWe`=0 right after the command byte. The slave samples `busRdata` in the cycle after that pulse and shifts the value out during the next byte. Any later byte in the same transaction returns 0x00 and issues no request.
- R6: Reading index 8 returns the selected channel's transmit free count, zero-extended, and issues no bus request.
- R7: Reading index 9 returns the selected channel's receive fill count, zero-extended, and issues no bus request.
- R8: Reading index 5 returns a status byte. Bit 0 is 1 when the receive fill count is nonzero. Bit 5 is 1 when the transmit free count equals the FIFO depth. All other bits are 0. Writes to index 5, 8 or 9 are dropped.
- R9: Channel 0 selects UART A and channel 1 selects UART B, and the channel appears on `busChan`. A channel value of `NUM_CH` or above issues no request, and a read with such a channel returns 0x00.
- R10: If chip select rises partway through a byte, the partial byte is discarded and issues no request. The next transaction starts with a fresh command byte.
- R11: After reset, `busReq` and `miso` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the SPI pins |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | SPI serial clock, idle low |
| mosi | input | 1 | Serial data from the host |
| csN | input | 1 | Active-low chip select |
| miso | output | 1 | Serial data to the host |
| busReq | output | 1 | One-cycle register access request |
| busWe | output | 1 | 1 for a write request, 0 for a read |
| busIdx | output | 4 | Register index of the request |
| busChan | output | 2 | UART channel of the request |
| busWdata | output | 8 | Write data of the request |
| busRdata | input | 8 | Read data, valid in the cycle after a read request |
| txFree | input | NUM_CH*LVL_W | Per-channel transmit FIFO free count, channel 0 in the low slice |
| rxLevel | input | NUM_CH*LVL_W | Per-channel receive FIFO fill count, channel 0 in the low slice |

## Verification
A bit counter that drifts out of step with the host shows up within the next command byte as a wrong index or channel on `busReq`. It can also appear as a request that is missing or extra. A transaction phase that fails to leave the write state shows up as extra write requests after the first data byte to a register other than 0. A read capture flag that stays armed or is lost shows up on MISO during the byte after the command: the returned value is wrong or shifted, or the byte after it is not 0x00. Each of these faults becomes visible at the ports within one byte time of the stimulus.

// File: rtl/spi_reg_pkg.sv
`timescale 1ns/1ps
package spi_reg_pkg;

  localparam logic [3:0] IDX_HOLD   = 4'd0;
  localparam logic [3:0] IDX_LINE   = 4'd5;
  localparam logic [3:0] IDX_TXROOM = 4'd8;
  localparam logic [3:0] IDX_RXFILL = 4'd9;

  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2,
    PH_SKIP  = 2'd3
  } phase_t;

  typedef struct packed {
    logic capWdata;
    logic capRdata;
  } dpStrobe_t;

  function automatic logic isLocal(input logic [3:0] idx);
    return (idx == IDX_LINE) || (idx == IDX_TXROOM) || (idx == IDX_RXFILL);
  endfunction

endpackage

// File: rtl/spi_reg_ctrl.sv
`timescale 1ns/1ps
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkRise,
  input  logic       csSel,
  input  logic [7:1] rxHead,
  output dpStrobe_t  strobe,
  output logic [3:0] cmdIdx,
  output logic [1:0] cmdChan,
  output logic       busReq,
  output logic       busWe
);

  logic [2:0] bitCnt;
  phase_t     phase;
  logic       rdWaitA;
  logic       rdWaitB;
  logic       byteDone;
  logic       newChanOk;
  logic       newLocal;
  logic       wrAllowed;

  assign byteDone  = csSel && sclkRise && (bitCnt == 3'd7);
  assign newChanOk = int'(rxHead[2:1]) < NUM_CH;
  assign newLocal  = isLocal(rxHead[6:3]);
  assign wrAllowed = (int'(cmdChan) < NUM_CH) && !isLocal(cmdIdx);

  always_comb begin
    strobe.capWdata = byteDone && (phase == PH_WRITE);
    strobe.capRdata = rdWaitB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      phase   <= PH_CMD;
      rdWaitA <= 1'b0;
      rdWaitB <= 1'b0;
      cmdIdx  <= '0;
      cmdChan <= '0;
      busReq  <= 1'b0;
      busWe   <= 1'b0;
    end else begin
      busReq  <= 1'b0;
      rdWaitA <= 1'b0;
      rdWaitB <= rdWaitA;
      if (!csSel) begin
        bitCnt  <= '0;
        phase   <= PH_CMD;
        rdWaitB <= 1'b0;
      end else begin
        if (sclkRise) bitCnt <= bitCnt + 3'd1;
        if (byteDone) begin
          case (phase)
            PH_CMD: begin
              cmdIdx  <= rxHead[6:3];
              cmdChan <= rxHead[2:1];
              if (rxHead[7]) begin
                phase   <= PH_READ;
                rdWaitA <= 1'b1;
                busReq  <= newChanOk && !newLocal;
                busWe   <= 1'b0;
              end else begin
                phase <= PH_WRITE;
              end
            end
            PH_WRITE: begin
              busReq <= wrAllowed;
              busWe  <= 1'b1;
              if (cmdIdx != IDX_HOLD) phase <= PH_SKIP;
            end
            default: phase <= PH_SKIP;
          endcase
        end
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    busReq |=> !busReq); // R3

  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (int'(cmdChan) < NUM_CH)); // R9

  AST_LOCAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !isLocal(cmdIdx)); // R6

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!csSel && !$past(csSel)) |-> !busReq); // R10

endmodule

// File: rtl/spi_reg_dp.sv
`timescale 1ns/1ps
module spi_reg_dp
  import spi_reg_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int FIFO_DEPTH = 64,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclk,
  input  logic                    mosi,
  input  logic                    csN,
  input  dpStrobe_t               strobe,
  input  logic [3:0]              cmdIdx,
  input  logic [1:0]              cmdChan,
  input  logic [7:0]              busRdata,
  input  logic [NUM_CH*LVL_W-1:0] txFree,
  input  logic [NUM_CH*LVL_W-1:0] rxLevel,
  output logic                    sclkRise,
  output logic                    csSel,
  output logic [7:0]              rxByteNext,
  output logic [7:0]              wdataQ,
  output logic                    miso
);

  logic [2:0] sclkS;
  logic [1:0] mosiS;
  logic [1:0] csS;
  logic       sclkFall;
  logic [6:0] rxSh;
  logic [6:0] txSh;
  logic [7:0] holdQ;
  logic       armQ;
  logic       misoQ;

  logic [LVL_W-1:0] txArr [NUM_CH];
  logic [LVL_W-1:0] rxArr [NUM_CH];
  logic [LVL_W-1:0] selTx;
  logic [LVL_W-1:0] selRx;
  logic             chanOk;
  logic [7:0]       readMux;

  // Pin synchronisers and edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkS <= '0;
      mosiS <= '0;
      csS   <= 2'b11;
    end else begin
      sclkS <= {sclkS[1:0], sclk};
      mosiS <= {mosiS[0], mosi};
      csS   <= {csS[0], csN};
    end
  end

  assign sclkRise   = sclkS[1] & ~sclkS[2];
  assign sclkFall   = ~sclkS[1] & sclkS[2];
  assign csSel      = ~csS[1];
  assign rxByteNext = {rxSh, mosiS[1]};

  // Receive shifter and write data capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSh   <= '0;
      wdataQ <= '0;
    end else begin
      if (!csSel) rxSh <= '0;
      else if (sclkRise) rxSh <= rxByteNext[6:0];
      if (strobe.capWdata) wdataQ <= rxByteNext;
    end
  end

  // Per-channel level slices
  for (genvar g = 0; g < NUM_CH; g++) begin : gLevel
    assign txArr[g] = txFree[g*LVL_W +: LVL_W];
    assign rxArr[g] = rxLevel[g*LVL_W +: LVL_W];
  end

  always_comb begin
    selTx  = '0;
    selRx  = '0;
    chanOk = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (cmdChan == 2'(c)) begin
        selTx  = txArr[c];
        selRx  = rxArr[c];
        chanOk = 1'b1;
      end
    end
    case (cmdIdx)
      IDX_LINE:   readMux = {2'b00, selTx == LVL_W'(FIFO_DEPTH), 4'b0000, selRx != '0};
      IDX_TXROOM: readMux = 8'(selTx);
      IDX_RXFILL: readMux = 8'(selRx);
      default:    readMux = busRdata;
    endcase
    if (!chanOk) readMux = 8'h00;
  end

  // Transmit shifter, updated after falling SCLK edges
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ <= '0;
      armQ  <= 1'b0;
      txSh  <= '0;
      misoQ <= 1'b0;
    end else if (!csSel) begin
      armQ  <= 1'b0;
      txSh  <= '0;
      misoQ <= 1'b0;
    end else begin
      if (strobe.capRdata) begin
        holdQ <= readMux;
        armQ  <= 1'b1;
      end
      if (sclkFall) begin
        if (armQ) begin
          misoQ <= holdQ[7];
          txSh  <= holdQ[6:0];
          armQ  <= 1'b0;
        end else begin
          misoQ <= txSh[6];
          txSh  <= {txSh[5:0], 1'b0};
        end
      end
    end
  end

  assign miso = misoQ;

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!csSel && !$past(csSel)) |-> !miso); // R1

  AST_MISO_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (csSel && $past(csSel) && !$past(sclkFall)) |-> $stable(miso)); // R1

endmodule

// File: rtl/spi_reg_slave.sv
`timescale 1ns/1ps
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int FIFO_DEPTH = 64,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclk,
  input  logic                    mosi,
  input  logic                    csN,
  output logic                    miso,
  output logic                    busReq,
  output logic                    busWe,
  output logic [3:0]              busIdx,
  output logic [1:0]              busChan,
  output logic [7:0]              busWdata,
  input  logic [7:0]              busRdata,
  input  logic [NUM_CH*LVL_W-1:0] txFree,
  input  logic [NUM_CH*LVL_W-1:0] rxLevel
);

  dpStrobe_t  strobe;
  logic       sclkRise;
  logic       csSel;
  logic [7:0] rxByteNext;

  spi_reg_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .sclkRise (sclkRise),
    .csSel    (csSel),
    .rxHead   (rxByteNext[7:1]),
    .strobe   (strobe),
    .cmdIdx   (busIdx),
    .cmdChan  (busChan),
    .busReq   (busReq),
    .busWe    (busWe)
  );

  spi_reg_dp #(.NUM_CH(NUM_CH), .FIFO_DEPTH(FIFO_DEPTH)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .sclk       (sclk),
    .mosi       (mosi),
    .csN        (csN),
    .strobe     (strobe),
    .cmdIdx     (busIdx),
    .cmdChan    (busChan),
    .busRdata   (busRdata),
    .txFree     (txFree),
    .rxLevel    (rxLevel),
    .sclkRise   (sclkRise),
    .csSel      (csSel),
    .rxByteNext (rxByteNext),
    .wdataQ     (busWdata),
    .miso       (miso)
  );

endmodule

// File: tb/spi_reg_slave_tb.sv
`timescale 1ns/1ps
module spi_reg_slave_tb_top;

  localparam int HALF  = 8;
  localparam int LVL_W = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic csN = 1'b1;
  logic miso;
  logic busReq, busWe;
  logic [3:0] busIdx;
  logic [1:0] busChan;
  logic [7:0] busWdata;
  logic [7:0] busRdata = 8'h00;
  logic [2*LVL_W-1:0] txFree = '0;
  logic [2*LVL_W-1:0] rxLevel = '0;

  int checks = 0;
  int fails = 0;
  bit doneFlag = 1'b0;

  logic [7:0] txBuf [0:15];
  logic [7:0] rxBuf [0:15];

  int         reqCount = 0;
  logic       logWe   [0:31];
  logic [3:0] logIdx  [0:31];
  logic [1:0] logChan [0:31];
  logic [7:0] logData [0:31];

  always #2.5 clk = ~clk;

  spi_reg_slave dut_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .mosi(mosi), .csN(csN), .miso(miso),
    .busReq(busReq), .busWe(busWe), .busIdx(busIdx), .busChan(busChan),
    .busWdata(busWdata), .busRdata(busRdata), .txFree(txFree), .rxLevel(rxLevel)
  );

  function automatic logic [7:0] rdVal(input logic [1:0] ch, input logic [3:0] idx);
    return {ch, idx, 2'b10};
  endfunction

  always @(posedge clk) begin
    if (rstN && busReq) begin
      if (reqCount < 32) begin
        logWe[reqCount]   <= busWe;
        logIdx[reqCount]  <= busIdx;
        logChan[reqCount] <= busChan;
        logData[reqCount] <= busWdata;
      end
      reqCount <= reqCount + 1;
      if (!busWe) busRdata <= rdVal(busChan, busIdx);
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic spiBits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i >= 8 - nb; i--) begin
      mosi = tx[i];
      waitClk(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic runXfer(input int n);
    logic [7:0] r;
    csN = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < n; i++) begin
      spiBits(txBuf[i], 8, r);
      rxBuf[i] = r;
    end
    waitClk(HALF);
    csN = 1'b1;
    waitClk(2 * HALF);
  endtask

  task automatic chkReq(input string req, input int k, input logic we,
                        input logic [3:0] idx, input logic [1:0] ch, input logic [7:0] d);
    chk({req, " we"}, int'(logWe[k]), int'(we));
    chk({req, " idx"}, int'(logIdx[k]), int'(idx));
    chk({req, " chan"}, int'(logChan[k]), int'(ch));
    if (we) chk({req, " wdata"}, int'(logData[k]), int'(d));
  endtask

  task automatic tReset;
    chk("R11 miso after reset", int'(miso), 0);
    chk("R11 busReq after reset", int'(busReq), 0);
    chk("R11 no request after reset", reqCount, 0);
  endtask

  task automatic tWrite;
    int b = reqCount;
    txBuf[0] = 8'h18; txBuf[1] = 8'h5A;
    runXfer(2);
    chk("R3 one write request", reqCount - b, 1);
    chkReq("R3", b, 1'b1, 4'd3, 2'd0, 8'h5A);
    chk("R1 miso zero on cmd byte", int'(rxBuf[0]), 0);
    chk("R1 miso zero on write data", int'(rxBuf[1]), 0);
    chk("R1 miso low when deselected", int'(miso), 0);
    b = reqCount;
    txBuf[0] = 8'h1B; txBuf[1] = 8'hC3;
    runXfer(2);
    chk("R2 reserved bit ignored", reqCount - b, 1);
    chkReq("R2", b, 1'b1, 4'd3, 2'd1, 8'hC3);
  endtask

  task automatic tWriteSingle;
    int b = reqCount;
    txBuf[0] = 8'h10; txBuf[1] = 8'h11; txBuf[2] = 8'h22; txBuf[3] = 8'h33;
    runXfer(4);
    chk("R3 extra bytes ignored", reqCount - b, 1);
    chkReq("R3 first byte only", b, 1'b1, 4'd2, 2'd0, 8'h11);
  endtask

  task automatic tBurst;
    int b = reqCount;
    txBuf[0] = 8'h02;
    for (int i = 1; i <= 4; i++) txBuf[i] = 8'hA0 + 8'(i);
    runXfer(5);
    chk("R4 burst request count", reqCount - b, 4);
    for (int i = 0; i < 4; i++) chkReq("R4 burst", b + i, 1'b1, 4'd0, 2'd1, 8'hA1 + 8'(i));
  endtask

  task automatic tRead;
    int b = reqCount;
    txBuf[0] = 8'h9A; txBuf[1] = 8'hFF; txBuf[2] = 8'hFF;
    runXfer(3);
    chk("R5 one read request", reqCount - b, 1);
    chkReq("R5", b, 1'b0, 4'd3, 2'd1, 8'h00);
    chk("R5 read data MSB first", int'(rxBuf[1]), int'(rdVal(2'd1, 4'd3)));
    chk("R5 trailing byte zero", int'(rxBuf[2]), 0);
    chk("R1 miso zero on read cmd", int'(rxBuf[0]), 0);
    b = reqCount;
    txBuf[0] = 8'h80; txBuf[1] = 8'hFF;
    runXfer(2);
    chk("R5 holding read request", reqCount - b, 1);
    chk("R5 holding read data", int'(rxBuf[1]), int'(rdVal(2'd0, 4'd0)));
  endtask

  task automatic readLocal(input logic [7:0] cmd, input string req, input int exp);
    int b = reqCount;
    txBuf[0] = cmd; txBuf[1] = 8'hFF;
    runXfer(2);
    chk({req, " value"}, int'(rxBuf[1]), exp);
    chk({req, " no bus request"}, reqCount - b, 0);
  endtask

  task automatic tLevels;
    txFree  = {7'd12, 7'd37};
    rxLevel = {7'd50, 7'd0};
    waitClk(2);
    readLocal(8'hC0, "R6 tx free chA", 37);
    readLocal(8'hC2, "R6 tx free chB", 12);
    readLocal(8'hC8, "R7 rx fill chA", 0);
    readLocal(8'hCA, "R7 rx fill chB", 50);
  endtask

  task automatic tLine;
    int b;
    txFree  = {7'd64, 7'd64};
    rxLevel = {7'd3, 7'd0};
    waitClk(2);
    readLocal(8'hA8, "R8 status empty tx", 8'h20);
    readLocal(8'hAA, "R8 status both bits", 8'h21);
    txFree  = {7'd64, 7'd10};
    rxLevel = {7'd3, 7'd5};
    waitClk(2);
    readLocal(8'hA8, "R8 status data ready", 8'h01);
    b = reqCount;
    txBuf[0] = 8'h28; txBuf[1] = 8'h55;
    runXfer(2);
    txBuf[0] = 8'h40; txBuf[1] = 8'h55;
    runXfer(2);
    chk("R8 local writes dropped", reqCount - b, 0);
  endtask

  task automatic tChan;
    int b = reqCount;
    txBuf[0] = 8'h1C; txBuf[1] = 8'h77;
    runXfer(2);
    chk("R9 bad channel write dropped", reqCount - b, 0);
    readLocal(8'h9E, "R9 bad channel read", 0);
    readLocal(8'hC4, "R9 bad channel level", 0);
  endtask

  task automatic tPartial;
    int b = reqCount;
    logic [7:0] r;
    csN = 1'b0;
    waitClk(HALF);
    spiBits(8'h18, 5, r);
    waitClk(HALF);
    csN = 1'b1;
    waitClk(2 * HALF);
    chk("R10 partial byte no request", reqCount - b, 0);
    txBuf[0] = 8'h18; txBuf[1] = 8'h66;
    runXfer(2);
    chk("R10 fresh transaction", reqCount - b, 1);
    chkReq("R10", b, 1'b1, 4'd3, 2'd0, 8'h66);
  endtask

  task automatic finishRun;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    waitClk(10);
    rstN = 1'b1;
    waitClk(4);
    tReset();
    tWrite();
    tWriteSingle();
    tBurst();
    tRead();
    tLevels();
    tLine();
    tChan();
    tPartial();
    doneFlag = 1'b1;
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      finishRun();
    end
  end

endmodule